// File: doc/BRIEF.md
# Receive Mailbox Bank with Match and Read Lock

This block holds a parameterised set of receive mailboxes for a CAN-style controller. Each mailbox has an acceptance identifier, an acceptance mask and a 4-bit state code. Each mailbox also stores the identifier, length, 64-bit payload and timestamp of the last frame it took. An upstream receive engine presents a finished frame for one cycle. The block picks a destination mailbox, moves the frame in, and raises that mailbox's flag. Each flag reaches a shared interrupt line only if its mask bit is set.

Software works through a small register port. Reads return data one cycle after the read strobe. A read of a mailbox's control/status word while that mailbox holds an unread frame locks the mailbox, so the frame cannot be overwritten while software drains it. Software must read the payload only when BUSY is clear. The lock is released by a read of the free-running timer, or by a control/status read of any other mailbox. While a mailbox is locked, frames that it would otherwise have taken go to other mailboxes or are dropped.

Address layout (`cpu_addr_i`, IW = log2(NUM_MB), NUM_MB a power of two from 2 to 32):
- Top bit 0 selects a mailbox. Bits [IW+2:3] hold the mailbox index and bits [2:0] the word: 0 control/status, 1 acceptance identifier, 2 acceptance mask, 3 received identifier (read only), 4 payload bits 31:0, 5 payload bits 63:32.
- Top bit 1 selects a global word: 0 timer (read), 1 flags (read), 2 flag clear (write 1 to clear), 3 interrupt mask (read/write).

Control/status word layout: [3:0] code, [4] BUSY, [11:8] length, [31:16] timestamp.

Top module: `mbx_rx_bank`

## Requirements
- R1: After reset, every code is INACTIVE (4'h0), all flags and interrupt mask bits are 0, `irq_o` is low and no mailbox is locked.
- R2: Codes are INACTIVE 4'h0, FULL 4'h2, EMPTY 4'h4 and OVERRUN 4'h6. A mailbox matches when it is not INACTIVE and `((rx_id ^ acceptance_id) & mask) == 0` over 11 bits. An INACTIVE mailbox never takes a frame.
- R3: A mailbox is free when it is unlocked and not busy, and its code is EMPTY, or FULL or OVERRUN with its flag clear. A frame goes to the lowest-indexed free matching mailbox, and that mailbox's code becomes FULL.
- R4: If no matching mailbox is free, the frame goes to the lowest-indexed matching mailbox that is unlocked and not busy, and that mailbox's code becomes OVERRUN.
- R5: If every matching mailbox is locked, the frame is dropped. No flag, code or payload changes.
- R6: A completed move-in sets the mailbox's flag. Writing 1s to the flag-clear word clears the flags at those bit positions. When a set and a clear fall in the same cycle, the set wins.
- R7: `irq_o` is high exactly when some flag and its interrupt mask bit are both 1. The mask has no effect on which mailbox is chosen.
- R8: A control/status read of a mailbox whose code is FULL or OVERRUN, and which is not busy, locks that mailbox. A locked mailbox's contents never change through move-in.
- R9: A read of the timer word releases the lock.
- R10: A control/status read of a different mailbox releases the lock, whatever that mailbox's code is.
- R11: A frame sampled with `rx_valid_i` is written at the second clock edge. In the cycle between the two edges, BUSY (bit 4) reads 1 for the destination mailbox.
- R12: The 16-bit timer increments every clock. The stored timestamp is the timer value in the cycle the frame is written. Read data appears on `cpu_rdata_o` after the edge that samples `cpu_rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received frame present this cycle |
| rx_id_i | input | ID_W | Received identifier |
| rx_len_i | input | 4 | Received data length |
| rx_data_i | input | 64 | Received payload |
| cpu_rd_i | input | 1 | Register read strobe |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_addr_i | input | IW+4 | Register address |
| cpu_wdata_i | input | 32 | Register write data |
| cpu_rdata_o | output | 32 | Register read data, one cycle after the read |
| irq_o | output | 1 | OR of flags gated by the interrupt mask |

## Verification
A frame is sampled at one edge and written at the next. Its flag, code and payload are therefore due two edges after `rx_valid_i`, and the bench's frame task returns only after the second falling edge. Register reads are captured at the edge that samples the strobe, so the bench reads `cpu_rdata_o` at the following falling edge. A control/status read issued one cycle after the frame sees BUSY, and a timer read followed at once by a frame predicts a timestamp two counts later. Lock, release and drop cases are checked through flags and payload reads taken after each frame completes. An acceptance sweep compares the flag against the mask equation for many identifier and mask pairs.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [3:0] MB_INACTIVE = 4'h0;
  localparam logic [3:0] MB_FULL     = 4'h2;
  localparam logic [3:0] MB_EMPTY    = 4'h4;
  localparam logic [3:0] MB_OVERRUN  = 4'h6;

  localparam int unsigned DATA_W = 64;
  localparam int unsigned LEN_W  = 4;
  localparam int unsigned TS_W   = 16;
  localparam int unsigned REG_W  = 32;

  // mailbox words
  localparam logic [2:0] W_CS   = 3'd0;
  localparam logic [2:0] W_FILT = 3'd1;
  localparam logic [2:0] W_MASK = 3'd2;
  localparam logic [2:0] W_RID  = 3'd3;
  localparam logic [2:0] W_DLO  = 3'd4;
  localparam logic [2:0] W_DHI  = 3'd5;
  // global words
  localparam logic [2:0] G_TMR  = 3'd0;
  localparam logic [2:0] G_FLAG = 3'd1;
  localparam logic [2:0] G_FCLR = 3'd2;
  localparam logic [2:0] G_IMSK = 3'd3;
endpackage

// File: rtl/mbx_match.sv
module mbx_match
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_MB = 16,
  parameter int unsigned ID_W   = 11
) (
  input  logic [ID_W-1:0]               id_i,
  input  logic [NUM_MB-1:0][ID_W-1:0]   filt_i,
  input  logic [NUM_MB-1:0][ID_W-1:0]   mask_i,
  input  logic [NUM_MB-1:0][3:0]        code_i,
  input  logic [NUM_MB-1:0]             flag_i,
  input  logic [NUM_MB-1:0]             lock_i,
  input  logic [NUM_MB-1:0]             busy_i,
  output logic [NUM_MB-1:0]             hit_o,
  output logic [NUM_MB-1:0]             free_o
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic act, eq, drained;
    assign act     = code_i[i] != MB_INACTIVE;
    assign eq      = ((id_i ^ filt_i[i]) & mask_i[i]) == '0;
    assign drained = (code_i[i] == MB_FULL || code_i[i] == MB_OVERRUN) && !flag_i[i];
    assign hit_o[i]  = act && eq && !lock_i[i] && !busy_i[i];
    assign free_o[i] = hit_o[i] && (code_i[i] == MB_EMPTY || drained);
  end
endmodule

// File: rtl/mbx_first.sv
module mbx_first #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/mbx_lock.sv
module mbx_lock #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_rd_i,
  input  logic [IW-1:0] cs_idx_i,
  input  logic          cs_full_i,
  input  logic          tmr_rd_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else if (tmr_rd_i) begin
      valid_o <= 1'b0;
    end else if (cs_rd_i) begin
      // any status read moves or drops the single lock
      valid_o <= cs_full_i;
      idx_o   <= cs_idx_i;
    end
  end

  assign vec_o = valid_o ? ({{(N-1){1'b0}}, 1'b1} << idx_o) : '0;
endmodule

// File: rtl/mbx_rx_bank.sv
module mbx_rx_bank
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_MB = 16,
  parameter int unsigned ID_W   = 11,
  localparam int unsigned IW    = $clog2(NUM_MB),
  localparam int unsigned AW    = IW + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [ID_W-1:0]   rx_id_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [REG_W-1:0]  cpu_wdata_i,
  output logic [REG_W-1:0]  cpu_rdata_o,
  output logic              irq_o
);
  logic [NUM_MB-1:0][3:0]        code_q;
  logic [NUM_MB-1:0][ID_W-1:0]   filt_q, mask_q, rid_q;
  logic [NUM_MB-1:0][LEN_W-1:0]  len_q;
  logic [NUM_MB-1:0][DATA_W-1:0] data_q;
  logic [NUM_MB-1:0][TS_W-1:0]   ts_q;
  logic [NUM_MB-1:0]             flag_q, imask_q;
  logic [TS_W-1:0]               tmr_q;

  logic              mv_valid_q, mv_ovr_q;
  logic [IW-1:0]     mv_idx_q;
  logic [ID_W-1:0]   mv_id_q;
  logic [LEN_W-1:0]  mv_len_q;
  logic [DATA_W-1:0] mv_data_q;

  logic              glob;
  logic [IW-1:0]     a_idx;
  logic [2:0]        a_word;
  logic              cs_rd, cs_full, tmr_rd, commit;
  logic [NUM_MB-1:0] busy_vec, lock_vec, hit, free, set_vec, clr_vec;
  logic              lock_valid, ff_found, fh_found;
  logic [IW-1:0]     lock_idx, ff_idx, fh_idx;
  logic [REG_W-1:0]  rd_mux;
  logic              unused_wdata;

  assign glob   = cpu_addr_i[AW-1];
  assign a_idx  = cpu_addr_i[IW+2:3];
  assign a_word = cpu_addr_i[2:0];
  assign unused_wdata = ^cpu_wdata_i;

  assign busy_vec = mv_valid_q ? ({{(NUM_MB-1){1'b0}}, 1'b1} << mv_idx_q) : '0;
  assign commit   = mv_valid_q && !lock_vec[mv_idx_q];

  mbx_match #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_match (
    .id_i(rx_id_i), .filt_i(filt_q), .mask_i(mask_q), .code_i(code_q),
    .flag_i(flag_q), .lock_i(lock_vec), .busy_i(busy_vec),
    .hit_o(hit), .free_o(free)
  );

  mbx_first #(.N(NUM_MB)) u_first_free (.req_i(free), .found_o(ff_found), .idx_o(ff_idx));
  mbx_first #(.N(NUM_MB)) u_first_hit  (.req_i(hit),  .found_o(fh_found), .idx_o(fh_idx));

  assign cs_rd   = cpu_rd_i && !glob && a_word == W_CS;
  assign cs_full = (code_q[a_idx] == MB_FULL || code_q[a_idx] == MB_OVERRUN) && !busy_vec[a_idx];
  assign tmr_rd  = cpu_rd_i && glob && a_word == G_TMR;

  mbx_lock #(.N(NUM_MB)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_rd_i(cs_rd), .cs_idx_i(a_idx),
    .cs_full_i(cs_full), .tmr_rd_i(tmr_rd),
    .valid_o(lock_valid), .idx_o(lock_idx), .vec_o(lock_vec)
  );

  // stage 1: choose destination
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mv_valid_q <= 1'b0;
      mv_ovr_q   <= 1'b0;
      mv_idx_q   <= '0;
      mv_id_q    <= '0;
      mv_len_q   <= '0;
      mv_data_q  <= '0;
    end else begin
      mv_valid_q <= rx_valid_i && (ff_found || fh_found);
      if (rx_valid_i) begin
        mv_ovr_q  <= !ff_found;
        mv_idx_q  <= ff_found ? ff_idx : fh_idx;
        mv_id_q   <= rx_id_i;
        mv_len_q  <= rx_len_i;
        mv_data_q <= rx_data_i;
      end
    end
  end

  // stage 2: move-in, plus software configuration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      filt_q <= '0;
      mask_q <= '0;
      rid_q  <= '0;
      len_q  <= '0;
      data_q <= '0;
      ts_q   <= '0;
    end else begin
      for (int i = 0; i < NUM_MB; i++) begin
        if (cpu_wr_i && !glob && a_idx == IW'(i)) begin
          case (a_word)
            W_CS:    code_q[i] <= cpu_wdata_i[3:0];
            W_FILT:  filt_q[i] <= cpu_wdata_i[ID_W-1:0];
            W_MASK:  mask_q[i] <= cpu_wdata_i[ID_W-1:0];
            default: ;
          endcase
        end
        if (commit && mv_idx_q == IW'(i)) begin
          code_q[i] <= mv_ovr_q ? MB_OVERRUN : MB_FULL;
          rid_q[i]  <= mv_id_q;
          len_q[i]  <= mv_len_q;
          data_q[i] <= mv_data_q;
          ts_q[i]   <= tmr_q;
        end
      end
    end
  end

  assign set_vec = commit ? ({{(NUM_MB-1){1'b0}}, 1'b1} << mv_idx_q) : '0;
  assign clr_vec = (cpu_wr_i && glob && a_word == G_FCLR) ? cpu_wdata_i[NUM_MB-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= '0;
      imask_q <= '0;
      tmr_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_vec) | set_vec;
      if (cpu_wr_i && glob && a_word == G_IMSK) imask_q <= cpu_wdata_i[NUM_MB-1:0];
      tmr_q <= tmr_q + 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (!glob) begin
      case (a_word)
        W_CS:    rd_mux = {ts_q[a_idx], 4'b0, len_q[a_idx], 3'b0, busy_vec[a_idx], code_q[a_idx]};
        W_FILT:  rd_mux = REG_W'(filt_q[a_idx]);
        W_MASK:  rd_mux = REG_W'(mask_q[a_idx]);
        W_RID:   rd_mux = REG_W'(rid_q[a_idx]);
        W_DLO:   rd_mux = data_q[a_idx][31:0];
        W_DHI:   rd_mux = data_q[a_idx][63:32];
        default: rd_mux = '0;
      endcase
    end else begin
      case (a_word)
        G_TMR:   rd_mux = REG_W'(tmr_q);
        G_FLAG:  rd_mux = REG_W'(flag_q);
        G_IMSK:  rd_mux = REG_W'(imask_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cpu_rdata_o <= '0;
    else if (cpu_rd_i) cpu_rdata_o <= rd_mux;
  end

  assign irq_o = |(flag_q & imask_q);
endmodule

// File: rtl/mbx_rx_bank_chk.sv
module mbx_rx_bank_chk
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_MB = 16,
  localparam int unsigned IW    = $clog2(NUM_MB)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [TS_W-1:0]                 tmr_i,
  input logic [NUM_MB-1:0]               busy_i,
  input logic                            lock_valid_i,
  input logic [IW-1:0]                   lock_idx_i,
  input logic [NUM_MB-1:0][TS_W-1:0]     ts_i,
  input logic [NUM_MB-1:0][DATA_W-1:0]   data_i,
  input logic                            tmr_rd_i,
  input logic                            commit_i,
  input logic [IW-1:0]                   mv_idx_i,
  input logic [NUM_MB-1:0]               flag_i,
  input logic [NUM_MB-1:0]               imask_i,
  input logic                            irq_i,
  input logic                            cs_rd_i,
  input logic [IW-1:0]                   cs_idx_i,
  input logic                            cs_full_i
);
  // R12
  tmr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> tmr_i == TS_W'($past(tmr_i) + 1'b1));

  // R11
  busy_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_i));

  // R8
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_valid_i |=> (!lock_valid_i || lock_idx_i != $past(lock_idx_i) ||
                      (data_i[lock_idx_i] == $past(data_i[lock_idx_i]) &&
                       ts_i[lock_idx_i] == $past(ts_i[lock_idx_i]))));

  // R9
  tmr_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_rd_i |=> !lock_valid_i);

  // R10
  other_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rd_i && !tmr_rd_i && lock_valid_i && cs_idx_i != lock_idx_i && !cs_full_i) |=> !lock_valid_i);

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> flag_i[$past(mv_idx_i)]);

  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imask_i == '0) |-> !irq_i);
endmodule

bind mbx_rx_bank mbx_rx_bank_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tmr_i(tmr_q), .busy_i(busy_vec),
  .lock_valid_i(lock_valid), .lock_idx_i(lock_idx), .ts_i(ts_q), .data_i(data_q),
  .tmr_rd_i(tmr_rd), .commit_i(commit), .mv_idx_i(mv_idx_q), .flag_i(flag_q),
  .imask_i(imask_q), .irq_i(irq_o), .cs_rd_i(cs_rd), .cs_idx_i(a_idx),
  .cs_full_i(cs_full)
);

// File: tb/sim_mbx_rx_bank.sv
`timescale 1ns/1ps
module sim_mbx_rx_bank;
  import mbx_pkg::*;
  localparam int unsigned NMB = 4;
  localparam int unsigned IDW = 11;
  localparam int unsigned IW  = 2;
  localparam int unsigned AW  = IW + 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rx_valid, cpu_rd, cpu_wr, irq;
  logic [IDW-1:0]    rx_id;
  logic [3:0]        rx_len;
  logic [63:0]       rx_data;
  logic [AW-1:0]     cpu_addr;
  logic [31:0]       cpu_wdata, cpu_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mbx_rx_bank #(.NUM_MB(NMB), .ID_W(IDW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_id_i(rx_id),
    .rx_len_i(rx_len), .rx_data_i(rx_data), .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .irq_o(irq)
  );

  function automatic logic [AW-1:0] mba(int idx, logic [2:0] w);
    return {1'b0, IW'(idx), w};
  endfunction
  function automatic logic [AW-1:0] ga(logic [2:0] w);
    return {1'b1, {IW{1'b0}}, w};
  endfunction
  function automatic logic [63:0] dat(int k);
    return {32'hA000_0000 + 32'(k), 32'h5000_0000 + 32'(k)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic send(logic [IDW-1:0] id, int k);
    rx_valid = 1'b1; rx_id = id; rx_len = 4'(k); rx_data = dat(k);
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, t;
    rst_n = 1'b0; rx_valid = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    rx_id = '0; rx_len = '0; rx_data = '0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(mba(0, W_CS), r);  chk("R1 code", r[3:0], 32'(MB_INACTIVE));
    rd(ga(G_FLAG), r);    chk("R1 flags", r, 0);
    rd(ga(G_IMSK), r);    chk("R1 imask", r, 0);
    chk("R1 irq", 32'(irq), 0);

    // mb0 exact 0x1F1, mb1 accepts all, mb2 inactive, mb3 0x3xx
    wr(mba(0, W_FILT), 32'h1F1); wr(mba(0, W_MASK), 32'h7FF); wr(mba(0, W_CS), 32'(MB_EMPTY));
    wr(mba(1, W_FILT), 32'h000); wr(mba(1, W_MASK), 32'h000); wr(mba(1, W_CS), 32'(MB_EMPTY));
    wr(mba(3, W_FILT), 32'h300); wr(mba(3, W_MASK), 32'h700); wr(mba(3, W_CS), 32'(MB_EMPTY));

    // R3 first free match wins
    send(11'h1F1, 1);
    rd(ga(G_FLAG), r);   chk("R3 dest mb0", r, 32'h1);
    chk("R7 irq masked", 32'(irq), 0);
    rd(mba(0, W_CS), r); chk("R3 code FULL", r[3:0], 32'(MB_FULL));
    chk("R12 len", r[11:8], 1);
    rd(mba(0, W_RID), r); chk("R3 rid", r, 32'h1F1);
    rd(mba(0, W_DLO), r); chk("R3 data", r, dat(1)[31:0]);

    // R8 locked mailbox skipped even when drained
    wr(ga(G_FCLR), 32'h1);
    rd(ga(G_FLAG), r);   chk("R6 clear", r, 0);
    send(11'h1F1, 2);
    rd(ga(G_FLAG), r);   chk("R8 redirected", r, 32'h2);
    rd(mba(0, W_DLO), r); chk("R8 mb0 kept", r, dat(1)[31:0]);

    // R9 timer read releases
    rd(ga(G_TMR), r);
    wr(ga(G_FCLR), 32'h2);
    send(11'h1F1, 3);
    rd(ga(G_FLAG), r);   chk("R9 back to mb0", r, 32'h1);
    rd(mba(0, W_DLO), r); chk("R9 data", r, dat(3)[31:0]);

    // R10 status read of another mailbox releases
    rd(mba(0, W_CS), r);
    wr(ga(G_FCLR), 32'hF);
    rd(mba(2, W_CS), r);
    send(11'h1F1, 4);
    rd(ga(G_FLAG), r);   chk("R10 mb0 again", r, 32'h1);

    // R4 overrun fallback
    send(11'h1F1, 5);
    rd(ga(G_FLAG), r);   chk("R3 next free mb1", r, 32'h3);
    send(11'h1F1, 6);
    rd(mba(0, W_CS), r); chk("R4 mb0 OVERRUN", r[3:0], 32'(MB_OVERRUN));
    rd(mba(0, W_DLO), r); chk("R4 mb0 data", r, dat(6)[31:0]);
    send(11'h1F1, 7);
    rd(mba(1, W_CS), r); chk("R4 skip locked, mb1 OVERRUN", r[3:0], 32'(MB_OVERRUN));
    rd(mba(1, W_DLO), r); chk("R4 mb1 data", r, dat(7)[31:0]);
    rd(mba(0, W_DLO), r); chk("R8 mb0 not rewritten", r, dat(6)[31:0]);

    // R5 drop when all matches locked
    rd(ga(G_TMR), r);
    wr(mba(1, W_CS), 32'(MB_INACTIVE));
    send(11'h305, 8);
    rd(ga(G_FLAG), r);   chk("R3 mb3 taken", r, 32'hB);
    rd(mba(3, W_CS), r); chk("R3 mb3 FULL", r[3:0], 32'(MB_FULL));
    wr(ga(G_FCLR), 32'hF);
    send(11'h305, 9);
    rd(ga(G_FLAG), r);   chk("R5 no flag", r, 0);
    rd(mba(3, W_DLO), r); chk("R5 data kept", r, dat(8)[31:0]);

    // R7 mask gates irq only
    rd(ga(G_TMR), r);
    send(11'h305, 10);
    rd(ga(G_FLAG), r);   chk("R7 dest with mask 0", r, 32'h8);
    chk("R7 irq off", 32'(irq), 0);
    wr(ga(G_IMSK), 32'h8); chk("R7 irq on", 32'(irq), 1);
    wr(ga(G_IMSK), 32'h1); chk("R7 other bit", 32'(irq), 0);

    // R12 timer step
    rd(ga(G_TMR), t);
    rd(ga(G_TMR), r);    chk("R12 timer step", r, (t + 1) & 32'hFFFF);

    // R11 busy window, R12 timestamp
    wr(ga(G_FCLR), 32'hF);
    rd(ga(G_TMR), t);
    rx_valid = 1'b1; rx_id = 11'h1F1; rx_len = 4'd11; rx_data = dat(11);
    @(negedge clk);
    rx_valid = 1'b0; cpu_rd = 1'b1; cpu_addr = mba(0, W_CS);
    @(negedge clk);
    cpu_rd = 1'b0;
    chk("R11 busy set", cpu_rdata[4], 1);
    rd(mba(0, W_CS), r);
    chk("R11 busy clear", r[4], 0);
    chk("R3 drained OVERRUN refilled FULL", r[3:0], 32'(MB_FULL));
    chk("R12 timestamp", r[31:16], (t + 2) & 32'hFFFF);

    // R2 acceptance sweep on mb2 only
    wr(mba(0, W_CS), 32'(MB_INACTIVE));
    wr(mba(3, W_CS), 32'(MB_INACTIVE));
    wr(ga(G_FCLR), 32'hF);
    wr(mba(2, W_FILT), 32'h2A5);
    wr(mba(2, W_CS), 32'(MB_EMPTY));
    for (int m = 0; m < 4; m++) begin
      logic [IDW-1:0] mk;
      mk = (m == 0) ? 11'h7FF : (m == 1) ? 11'h70F : (m == 2) ? 11'h0F0 : 11'h000;
      wr(mba(2, W_MASK), 32'(mk));
      for (int k = 0; k < 32; k++) begin
        logic [IDW-1:0] id;
        logic           hit;
        id  = 11'h2A5 ^ IDW'(k * 32'h0A3);
        hit = ((id ^ 11'h2A5) & mk) == '0;
        send(id, k);
        rd(ga(G_FLAG), r);
        chk("R2 match sweep", r, hit ? 32'h4 : 32'h0);
        if (hit) wr(ga(G_FCLR), 32'h4);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule